// File: doc/BRIEF.md
# FP8 to BFloat16 Deinterleaving Converter

This block widens a vector of packed 8-bit floating-point bytes into two vectors of BFloat16 values. Each byte is decoded in one of two 8-bit layouts, divided by a power of two taken from a 6-bit scale, and written out as a BFloat16 word. Bytes at even positions fill the lanes of the even output vector, and bytes at odd positions fill the lanes of the odd output vector. Each output vector is as wide as the input vector. There is no lane masking: every lane of both outputs is written on every transfer.

Two control sets are available, each with its own scale and layout select. A per-transfer variant bit picks the control set, and that control set is captured together with the data.

The data path is a single registered stage with valid/ready handshakes on both sides. An input is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result is presented on the next cycle and stays on the outputs until the consumer raises `out_ready`. `in_ready` is high whenever the output register is empty or is being drained in that cycle, so the stage can run at one transfer per clock. Once the producer raises `in_valid`, it must hold it and its data until a transfer happens.

Top module: `fp8_bf16_deint`

## Requirements
- R1: For each pair index p, input byte 2p (bits 16p+7..16p) sets lane p (bits 16p+15..16p) of `out_even`, and input byte 2p+1 sets lane p of `out_odd`.
- R2: Layout select 0 decodes a byte as sign bit 7, exponent bits 6..2 with bias 15, and mantissa bits 1..0. Exponent 31 with mantissa 0 is an infinity. Layout select 1 decodes a byte as sign bit 7, exponent bits 6..3 with bias 7, and mantissa bits 2..0. This layout has no infinity. In both layouts, exponent 0 means subnormal: 0.m × 2^(1-bias).
- R3: Every NaN input produces 0x7FC0. For layout 0, a NaN is exponent 31 with a nonzero mantissa. For layout 1, a NaN is bits 6..0 equal to 0x7F.
- R4: A finite nonzero value v gives the exact BFloat16 encoding of v × 2^-s, with bias 127 and a 7-bit fraction, where s (0..63) is the selected scale. Subnormal inputs come out as normal BFloat16 numbers. A zero gives a zero of the same sign, and an infinity gives 0x7F80 or 0xFF80 according to its sign.
- R5: With `in_variant` = 0 the conversion uses `scale_a` and `fmt_a`. With `in_variant` = 1 it uses `scale_b` and `fmt_b`. The control set that is not selected has no effect on the result.
- R6: A transfer accepted at a clock edge sets `out_valid` after that edge and shows its result in that same cycle. If the output is drained while no new transfer is accepted, `out_valid` drops after that edge.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_even` and `out_odd` hold their values.
- R8: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R9: While reset is asserted and after its release, `out_valid` is low until the first transfer is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input vector offered |
| in_ready | output | 1 | Stage can take an input this cycle |
| in_vec | input | VEC_W | Packed 8-bit floating-point elements |
| in_variant | input | 1 | Control set select (0 = set A, 1 = set B) |
| scale_a | input | 6 | Downscale exponent of set A |
| fmt_a | input | 1 | Layout select of set A |
| scale_b | input | 6 | Downscale exponent of set B |
| fmt_b | input | 1 | Layout select of set B |
| out_valid | output | 1 | Result vectors valid |
| out_ready | input | 1 | Consumer takes the result |
| out_even | output | VEC_W | BFloat16 lanes from even-indexed bytes |
| out_odd | output | VEC_W | BFloat16 lanes from odd-indexed bytes |

## Verification
Every result is due exactly one clock edge after the edge that accepts its input. The bench drives each input at a falling edge and reads both output vectors at the following falling edge, half a cycle after the register loads. In the back-pressure scenario the bench holds `out_ready` low for several cycles, checking at each falling edge that `in_ready` stays low and the first result does not change. It then releases `out_ready` and expects the queued vector one edge later, followed by `out_valid` dropping at the next edge. The sweep covers all 256 byte codes in both layouts, at scales 0, 1, 31 and 63, through both variants. In each case the set that is not selected holds different values, and every lane is compared with an arithmetic reference model.

// File: rtl/fp8cvt_pkg.sv
package fp8cvt_pkg;

  localparam int SCALE_W  = 6;
  localparam int EXP_W    = 7;    // signed unbiased exponent width, two's complement
  localparam int FRAC_W   = 3;    // common fraction width after alignment
  localparam int BF_BIAS  = 127;
  localparam logic [15:0] BF_QNAN = 16'h7FC0;

  typedef enum logic {
    FMT_E5M2 = 1'b0,
    FMT_E4M3 = 1'b1
  } fp8_fmt_e;

  typedef enum logic [1:0] {
    CLS_ZERO   = 2'd0,
    CLS_FINITE = 2'd1,
    CLS_INF    = 2'd2,
    CLS_NAN    = 2'd3
  } fp8_cls_e;

  typedef struct packed {
    logic [SCALE_W-1:0] scale;
    fp8_fmt_e           fmt;
  } cvt_ctrl_t;

  typedef struct packed {
    logic              sign;
    fp8_cls_e          cls;
    logic [EXP_W-1:0]  exp_unb;
    logic [FRAC_W-1:0] frac;
  } fp8_norm_t;

endpackage

// File: rtl/fp8_unpack.sv
module fp8_unpack
  import fp8cvt_pkg::*;
(
  input  logic [7:0] code,
  input  fp8_fmt_e   fmt,
  output fp8_norm_t  norm
);

  logic [4:0]        efield;
  logic [FRAC_W-1:0] m3;
  logic              exp_full;
  logic              has_inf;
  logic              nan_hit;
  logic [EXP_W-1:0]  bias;
  logic [EXP_W-1:0]  emin;
  logic [1:0]        lead;
  logic [FRAC_W-1:0] sub_frac;
  logic [EXP_W-1:0]  sub_exp;

  // Field split per layout; mantissa aligned to a common 3-bit fraction
  always_comb begin
    if (fmt == FMT_E5M2) begin
      efield   = code[6:2];
      m3       = {code[1:0], 1'b0};
      exp_full = (code[6:2] == 5'h1F);
      has_inf  = 1'b1;
      nan_hit  = exp_full && (code[1:0] != 2'b00);
      bias     = EXP_W'(15);
      emin     = EXP_W'(-14);
    end else begin
      efield   = {1'b0, code[6:3]};
      m3       = code[2:0];
      exp_full = (code[6:3] == 4'hF);
      has_inf  = 1'b0;
      nan_hit  = (code[6:0] == 7'h7F);
      bias     = EXP_W'(7);
      emin     = EXP_W'(-6);
    end
  end

  // Leading-one position of a subnormal mantissa
  always_comb begin
    if (m3[2])      lead = 2'd2;
    else if (m3[1]) lead = 2'd1;
    else            lead = 2'd0;
  end

  always_comb begin
    sub_frac = m3 << (2'd3 - {1'b0, lead});
    sub_exp  = emin - EXP_W'(3) + EXP_W'(lead);
  end

  always_comb begin
    norm.sign    = code[7];
    norm.cls     = CLS_FINITE;
    norm.exp_unb = {2'b00, efield} - bias;
    norm.frac    = m3;
    if (nan_hit) begin
      norm.cls = CLS_NAN;
    end else if (exp_full && has_inf) begin
      norm.cls = CLS_INF;
    end else if (efield == 5'd0) begin
      if (m3 == '0) begin
        norm.cls = CLS_ZERO;
      end else begin
        norm.exp_unb = sub_exp;
        norm.frac    = sub_frac;
      end
    end
  end

endmodule

// File: rtl/bf16_scale_pack.sv
module bf16_scale_pack
  import fp8cvt_pkg::*;
(
  input  fp8_norm_t          norm,
  input  logic [SCALE_W-1:0] scale,
  output logic [15:0]        bf
);

  localparam int SUM_W = 10;

  logic [SUM_W-1:0] biased;

  // Exact: smallest finite result keeps the biased exponent well above zero
  always_comb begin
    biased = {{(SUM_W-EXP_W){norm.exp_unb[EXP_W-1]}}, norm.exp_unb}
             + SUM_W'(BF_BIAS)
             - {{(SUM_W-SCALE_W){1'b0}}, scale};
  end

  always_comb begin
    unique case (norm.cls)
      CLS_ZERO:   bf = {norm.sign, 15'd0};
      CLS_INF:    bf = {norm.sign, 8'hFF, 7'd0};
      CLS_NAN:    bf = BF_QNAN;
      default:    bf = {norm.sign, biased[7:0], norm.frac, {(7-FRAC_W){1'b0}}};
    endcase
  end

  always_comb begin
    if (bf[14:7] == 8'hFF && bf[6:0] != 7'd0) begin
      AST_NAN_CANON: assert (bf == BF_QNAN); // R3
    end
    if (bf[14:7] == 8'h00) begin
      AST_NO_SUBNORM_OUT: assert (bf[6:0] == 7'd0); // R4
    end
  end

endmodule

// File: rtl/fp8_lane_array.sv
module fp8_lane_array
  import fp8cvt_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0] vec,
  input  cvt_ctrl_t        ctrl,
  output logic [VEC_W-1:0] even_vec,
  output logic [VEC_W-1:0] odd_vec
);

  localparam int PAIRS = VEC_W / 16;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    for (genvar h = 0; h < 2; h++) begin : g_half
      fp8_norm_t   nrm;
      logic [15:0] word;

      fp8_unpack u_unpack (
        .code (vec[16*p + 8*h +: 8]),
        .fmt  (ctrl.fmt),
        .norm (nrm)
      );

      bf16_scale_pack u_pack (
        .norm  (nrm),
        .scale (ctrl.scale),
        .bf    (word)
      );

      if (h == 0) begin : g_even
        assign even_vec[16*p +: 16] = word;
      end else begin : g_odd
        assign odd_vec[16*p +: 16] = word;
      end
    end
  end

endmodule

// File: rtl/fp8_bf16_deint.sv
module fp8_bf16_deint
  import fp8cvt_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [VEC_W-1:0]   in_vec,
  input  logic               in_variant,
  input  logic [SCALE_W-1:0] scale_a,
  input  logic               fmt_a,
  input  logic [SCALE_W-1:0] scale_b,
  input  logic               fmt_b,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [VEC_W-1:0]   out_even,
  output logic [VEC_W-1:0]   out_odd
);

  cvt_ctrl_t        sel_ctrl;
  logic [VEC_W-1:0] cvt_even;
  logic [VEC_W-1:0] cvt_odd;
  logic             take;

  always_comb begin
    if (in_variant) begin
      sel_ctrl.scale = scale_b;
      sel_ctrl.fmt   = fp8_fmt_e'(fmt_b);
    end else begin
      sel_ctrl.scale = scale_a;
      sel_ctrl.fmt   = fp8_fmt_e'(fmt_a);
    end
  end

  fp8_lane_array #(.VEC_W(VEC_W)) u_lanes (
    .vec      (in_vec),
    .ctrl     (sel_ctrl),
    .even_vec (cvt_even),
    .odd_vec  (cvt_odd)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_even <= '0;
      out_odd  <= '0;
    end else if (take) begin
      out_even <= cvt_even;
      out_odd  <= cvt_odd;
    end
  end

  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R6
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid); // R6
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_even) && $stable(out_odd)); // R7
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R8
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !out_valid); // R9

endmodule

// File: tb/fp8_bf16_deint_bench.sv
module fp8_bf16_deint_bench;

  localparam int VEC_W = 128;
  localparam int PAIRS = VEC_W / 16;
  localparam int NB    = VEC_W / 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [VEC_W-1:0] in_vec = '0;
  logic             in_variant = 1'b0;
  logic [5:0]       scale_a = '0;
  logic             fmt_a = 1'b0;
  logic [5:0]       scale_b = '0;
  logic             fmt_b = 1'b0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [VEC_W-1:0] out_even;
  logic [VEC_W-1:0] out_odd;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  fp8_bf16_deint #(.VEC_W(VEC_W)) u_fp8_bf16_deint (
    .clk, .rst_n, .in_valid, .in_ready, .in_vec, .in_variant,
    .scale_a, .fmt_a, .scale_b, .fmt_b,
    .out_valid, .out_ready, .out_even, .out_odd
  );

  // Arithmetic reference: value = sig * 2^e2, renormalized into BFloat16
  function automatic logic [15:0] ref_bf(input logic [7:0] b, input bit f, input int s);
    int mw, ew, bias, ef, mf, sig, e2, pos;
    logic sgn;
    sgn = b[7];
    mw  = f ? 3 : 2;
    ew  = 7 - mw;
    bias = f ? 7 : 15;
    ef = int'(b[6:0]) >> mw;
    mf = int'(b[6:0]) & ((1 << mw) - 1);
    if (!f && ef == 31) return (mf != 0) ? 16'h7FC0 : {sgn, 15'h7F80};
    if (f && ef == 15 && mf == 7) return 16'h7FC0;
    if (ef == 0 && mf == 0) return {sgn, 15'd0};
    sig = (ef == 0) ? mf : (mf | (1 << mw));
    e2  = ((ef == 0) ? 1 : ef) - bias - mw;
    pos = 0;
    for (int k = 0; k < 8; k++) if ((sig >> k) & 1) pos = k;
    return {sgn, 8'(e2 + pos + 127 - s), 7'((sig << (7 - pos)) & 8'h7F)};
    if (ew < 0) return 16'h0;
  endfunction

  task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic chk_lanes(input string req, input logic [VEC_W-1:0] v, input bit f, input int s);
    for (int p = 0; p < PAIRS; p++) begin
      chk(req, 128'(out_even[16*p +: 16]), 128'(ref_bf(v[16*p +: 8], f, s)));
      chk(req, 128'(out_odd[16*p +: 16]),  128'(ref_bf(v[16*p+8 +: 8], f, s)));
    end
  endtask

  task automatic send(input logic [VEC_W-1:0] v, input bit var_b);
    @(negedge clk);
    in_vec = v;
    in_variant = var_b;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [VEC_W-1:0] va, vb;
    int scl [4] = '{0, 1, 31, 63};

    repeat (3) @(negedge clk);
    chk("R9 reset out_valid", 128'(out_valid), 128'(0));
    chk("R8 reset in_ready", 128'(in_ready), 128'(1));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle after reset", 128'(out_valid), 128'(0));

    // Full sweep: R1 R2 R3 R4 R5 R6
    for (int f = 0; f < 2; f++) begin
      for (int si = 0; si < 4; si++) begin
        for (int vb_sel = 0; vb_sel < 2; vb_sel++) begin
          if (vb_sel == 0) begin
            scale_a = 6'(scl[si]); fmt_a = f[0];
            scale_b = 6'(17);      fmt_b = ~f[0];
          end else begin
            scale_b = 6'(scl[si]); fmt_b = f[0];
            scale_a = 6'(23);      fmt_a = ~f[0];
          end
          for (int blk = 0; blk < 256 / NB; blk++) begin
            logic [VEC_W-1:0] v;
            for (int i = 0; i < NB; i++) v[8*i +: 8] = 8'(blk * NB + i);
            send(v, vb_sel[0]);
            chk("R6 valid after accept", 128'(out_valid), 128'(1));
            chk_lanes("R1 R2 R3 R4 R5 sweep", v, f[0], scl[si]);
          end
        end
      end
    end
    @(negedge clk);
    chk("R6 drop after drain", 128'(out_valid), 128'(0));

    // Back-pressure: R7 R8
    scale_a = 6'd3; fmt_a = 1'b1;
    for (int i = 0; i < NB; i++) begin
      va[8*i +: 8] = 8'(8'h38 + 3 * i);
      vb[8*i +: 8] = 8'(8'hA1 + 5 * i);
    end
    out_ready = 1'b0;
    @(negedge clk);
    in_vec = va; in_variant = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    chk("R6 first result valid", 128'(out_valid), 128'(1));
    chk("R8 ready low while stalled", 128'(in_ready), 128'(0));
    in_vec = vb;
    repeat (3) begin
      @(negedge clk);
      chk("R7 valid held", 128'(out_valid), 128'(1));
      chk("R8 ready low while stalled", 128'(in_ready), 128'(0));
      chk_lanes("R7 data held", va, 1'b1, 3);
    end
    out_ready = 1'b1;
    #0;
    chk("R8 ready with out_ready", 128'(in_ready), 128'(1));
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6 queued vector valid", 128'(out_valid), 128'(1));
    chk_lanes("R1 queued vector", vb, 1'b1, 3);
    @(negedge clk);
    chk("R6 drop after last drain", 128'(out_valid), 128'(0));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule